// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers the single-cycle event pulses that a display controller raises during scan-out and turns them into one interrupt request line. The five sources are frame done, sync lost, palette load complete, FIFO underflow and end of frame. Each source latches into its own sticky status bit. A separate enable mask decides which pending bits may reach the interrupt line.

Software reaches the block through a small register port. The port has one write strobe, an address and a write data bus, and its read data follows the address combinationally.

- **Enables:** the enable mask changes only through two write-only views. One view sets bits and the other clears bits. Both views read back the live mask.
- **Status:** status bits are cleared by writing ones to them.
- **Hold-off:** once the line has dropped after service, it stays low until software writes the end-of-interrupt register. This means a handler that clears status and then writes end-of-interrupt sees a clean edge for the next event.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset every status bit and every enable bit is 0, the interrupt line is low, and the line is armed, so the first enabled event needs no end-of-interrupt write.
- R2: A high event pulse sets its status bit on the next clock edge, whatever the enable is. The bit map is: bit 0 end of frame, bit 1 FIFO underflow, bit 2 palette load complete, bit 3 sync lost, bit 4 frame done. Address 0 reads the raw status in those bit positions.
- R3: A write to address 0 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. Writing all ones clears every pending bit.
- R4: If an event pulse and a clearing write to the same status bit fall in the same cycle, the bit is set afterwards.
- R5: A write to address 2 turns on each enable bit whose data bit is 1, and zero data bits leave enables unchanged. Reads of address 2 and of address 3 both return the current enable mask.
- R6: A write to address 3 turns off each enable bit whose data bit is 1, and zero data bits leave enables unchanged.
- R7: Address 1 reads the status ANDed with the enables. While the line is armed, the interrupt output is high exactly when that masked value is non-zero, in the cycle after the edge that changed status or enables.
- R8: When the interrupt line falls in a cycle with no end-of-interrupt write, the line is disarmed. It then stays low whatever events arrive until an end-of-interrupt write.
- R9: A write to address 4 (data ignored) re-arms the line. In the following cycle the line is high if any enabled status bit is pending, and low otherwise.
- R10: Writes to addresses 5 to 7 change no status, enable or line state. Reads of addresses 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_frame_end | input | 1 | End-of-frame event pulse (status bit 0) |
| ev_fifo_under | input | 1 | FIFO underflow event pulse (status bit 1) |
| ev_pal_done | input | 1 | Palette load complete event pulse (status bit 2) |
| ev_sync_lost | input | 1 | Sync lost event pulse (status bit 3) |
| ev_raster_done | input | 1 | Frame done pulse after raster stop (status bit 4) |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data for reg_addr |
| irq_o | output | 1 | Interrupt request line |

## Verification
Directed sequences separate the paths that a single random stream could blur:
- events with all enables off, which shows that status latching does not depend on enables;
- partial and all-ones clearing writes, which separate per-bit clearing from a global reset;
- a clear colliding with an event on one bit, which shows that the set has priority;
- set and clear writes with mixed zero bits, which show that untouched enables are preserved;
- a fall of the line followed by fresh events, with and without an end-of-interrupt write, which separates the hold-off from plain masking.

A long seeded random stream then mixes events on every source with every register operation, including unused addresses. Each cycle, the line and the read data are compared against a bench model built from the requirements.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    localparam int unsigned NSRC = 5;

    // status and enable bit positions
    localparam int unsigned BIT_FRAME_END  = 0;
    localparam int unsigned BIT_FIFO_UNDER = 1;
    localparam int unsigned BIT_PAL_DONE   = 2;
    localparam int unsigned BIT_SYNC_LOST  = 3;
    localparam int unsigned BIT_RASTER_DN  = 4;

    typedef enum logic [2:0] {
        RA_RAW_STAT    = 3'd0,
        RA_MASKED_STAT = 3'd1,
        RA_EN_SET      = 3'd2,
        RA_EN_CLR      = 3'd3,
        RA_EOI         = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/disp_irq_status.sv
module disp_irq_status #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    typedef struct packed {
        logic [N-1:0] stat;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a pulse in the same cycle as a clear wins
        st_d.stat = (st_q.stat & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));  // R2
    AST_CLR_WITH_EVT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & evt_i) != '0) |=> ((stat_o & $past(clr_i & evt_i)) != '0));  // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0) |=> ((stat_o & $past(clr_i & ~evt_i)) == '0));  // R3
    AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(clr_i | evt_i)) == ($past(stat_o) & ~$past(clr_i | evt_i))));  // R3

endmodule

// File: rtl/disp_irq_enable.sv
module disp_irq_enable #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] en_o
);

    typedef struct packed {
        logic [N-1:0] en;
    } en_state_t;

    en_state_t en_d, en_q;

    always_comb begin
        en_d    = en_q;
        en_d.en = (en_q.en & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o = en_q.en;

    AST_EN_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((en_o & $past(set_i)) == $past(set_i)));  // R5
    AST_EN_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((en_o & $past(clr_i & ~set_i)) == '0));  // R6
    AST_EN_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_o & ~$past(set_i | clr_i)) == ($past(en_o) & ~$past(set_i | clr_i))));  // R5

endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eoi_i,
    output logic irq_o
);

    typedef struct packed {
        logic armed;
        logic was_high;
    } line_state_t;

    line_state_t ln_d, ln_q;

    assign irq_o = ln_q.armed & pend_i;

    always_comb begin
        ln_d          = ln_q;
        ln_d.was_high = irq_o;
        if (eoi_i) begin
            ln_d.armed = 1'b1;
        end else if (ln_q.was_high && !irq_o) begin
            ln_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '{armed: 1'b1, was_high: 1'b0};
        else        ln_q <= ln_d;
    end

    AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_q.was_high && !irq_o && !eoi_i) |=> !irq_o);  // R8
    AST_EOI_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> (irq_o == pend_i));  // R9

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
    import disp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_frame_end,
    input  logic              ev_fifo_under,
    input  logic              ev_pal_done,
    input  logic              ev_sync_lost,
    input  logic              ev_raster_done,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    output logic              irq_o
);

    logic [NSRC-1:0] evt_vec;
    logic [NSRC-1:0] stat_clr, en_set, en_clr;
    logic [NSRC-1:0] stat_q, en_q, masked;
    logic            eoi_wr;
    logic            sel_raw, sel_masked, sel_set, sel_clr, sel_eoi;

    always_comb begin
        evt_vec                 = '0;
        evt_vec[BIT_FRAME_END]  = ev_frame_end;
        evt_vec[BIT_FIFO_UNDER] = ev_fifo_under;
        evt_vec[BIT_PAL_DONE]   = ev_pal_done;
        evt_vec[BIT_SYNC_LOST]  = ev_sync_lost;
        evt_vec[BIT_RASTER_DN]  = ev_raster_done;
    end

    assign sel_raw    = (reg_addr == ADDR_W'(RA_RAW_STAT));
    assign sel_masked = (reg_addr == ADDR_W'(RA_MASKED_STAT));
    assign sel_set    = (reg_addr == ADDR_W'(RA_EN_SET));
    assign sel_clr    = (reg_addr == ADDR_W'(RA_EN_CLR));
    assign sel_eoi    = (reg_addr == ADDR_W'(RA_EOI));

    assign stat_clr = (reg_wen && sel_raw) ? reg_wdata : '0;
    assign en_set   = (reg_wen && sel_set) ? reg_wdata : '0;
    assign en_clr   = (reg_wen && sel_clr) ? reg_wdata : '0;
    assign eoi_wr   = reg_wen && sel_eoi;

    disp_irq_status #(.N(NSRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_vec),
        .clr_i  (stat_clr),
        .stat_o (stat_q)
    );

    disp_irq_enable #(.N(NSRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en_q)
    );

    assign masked = stat_q & en_q;

    disp_irq_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (|masked),
        .eoi_i  (eoi_wr),
        .irq_o  (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_raw)               reg_rdata = stat_q;
        else if (sel_masked)       reg_rdata = masked;
        else if (sel_set | sel_clr) reg_rdata = en_q;
    end

    AST_LINE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((stat_q & en_q) != '0));  // R7
    AST_UNUSED_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && !(sel_raw | sel_masked | sel_set | sel_clr | sel_eoi) && evt_vec == '0)
        |=> (stat_q == $past(stat_q) && en_q == $past(en_q)));  // R10

endmodule

// File: tb/tb_disp_irq_ctrl.sv
module tb_disp_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev = '0;
    logic       wen = 1'b0;
    logic [2:0] addr = '0;
    logic [4:0] wdata = '0;
    logic [4:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [4:0] m_stat = '0, m_en = '0;
    logic       m_armed = 1'b1, m_was = 1'b0;

    always #4 clk = ~clk;

    disp_irq_ctrl #(.ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_frame_end(ev[0]), .ev_fifo_under(ev[1]), .ev_pal_done(ev[2]),
        .ev_sync_lost(ev[3]), .ev_raster_done(ev[4]),
        .reg_wen(wen), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_o(irq)
    );

    function automatic logic exp_irq();
        return m_armed & (|(m_stat & m_en));
    endfunction

    function automatic logic [4:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0:       return m_stat;
            3'd1:       return m_stat & m_en;
            3'd2, 3'd3: return m_en;
            default:    return 5'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive one cycle, check outputs of the current state, advance the model
    task automatic step(input logic [4:0] e, input logic w, input logic [2:0] a,
                        input logic [4:0] d, input string tag);
        logic nowi;
        @(negedge clk);
        ev = e; wen = w; addr = a; wdata = d;
        #1;
        chk({tag, " irq"}, {4'd0, irq}, {4'd0, exp_irq()});
        chk({tag, " rdata"}, rdata, exp_rd(a));
        nowi = exp_irq();
        if (w && a == 3'd0) m_stat = m_stat & ~d;
        m_stat = m_stat | e;
        if (w && a == 3'd2) m_en = m_en | d;
        if (w && a == 3'd3) m_en = m_en & ~d;
        if (w && a == 3'd4) m_armed = 1'b1;
        else if (m_was && !nowi) m_armed = 1'b0;
        m_was = nowi;
    endtask

    task automatic idle(input logic [2:0] a, input string tag);
        step(5'd0, 1'b0, a, 5'd0, tag);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(3'd0, "R1 raw");
        idle(3'd2, "R1 en");
        idle(3'd1, "R1 masked");
        // R2 events latch with enables off; bit0..4 mapping
        step(5'b10101, 1'b0, 3'd0, 5'd0, "R2 pulse");
        idle(3'd0, "R2 latched");
        step(5'b01010, 1'b0, 3'd0, 5'd0, "R2 pulse2");
        idle(3'd0, "R2 all set");
        // R3 partial clear then all-ones
        step(5'd0, 1'b1, 3'd0, 5'b00101, "R3 partial");
        idle(3'd0, "R3 partial result");
        step(5'd0, 1'b1, 3'd0, 5'b11111, "R3 all ones");
        idle(3'd0, "R3 all clear");
        // R4 collision
        step(5'b00010, 1'b1, 3'd0, 5'b00010, "R4 collide");
        idle(3'd0, "R4 kept");
        // R5 set, zero bits inert, read via both views
        step(5'd0, 1'b1, 3'd2, 5'b00011, "R5 set");
        step(5'd0, 1'b1, 3'd2, 5'b00100, "R5 set more");
        idle(3'd2, "R5 read set view");
        idle(3'd3, "R5 read clr view");
        // R7 line high from pending bit1 enabled
        idle(3'd1, "R7 masked");
        // R6 clear enable bit1 -> line falls -> disarm
        step(5'd0, 1'b1, 3'd3, 5'b00010, "R6 clear");
        idle(3'd3, "R6 result");
        // R8 new enabled event while disarmed stays low
        step(5'b00001, 1'b0, 3'd1, 5'd0, "R8 event");
        idle(3'd1, "R8 held low");
        idle(3'd0, "R8 held low2");
        // R9 EOI re-arms with pending
        step(5'd0, 1'b1, 3'd4, 5'b10101, "R9 eoi");
        idle(3'd4, "R9 line up");
        // clear all, line falls, EOI with nothing pending
        step(5'd0, 1'b1, 3'd0, 5'b11111, "R9 clear");
        idle(3'd0, "R9 fallen");
        step(5'd0, 1'b1, 3'd4, 5'd0, "R9 eoi empty");
        idle(3'd1, "R9 stays low");
        step(5'b00100, 1'b0, 3'd1, 5'd0, "R9 fresh event");
        idle(3'd1, "R9 fresh irq");
        // R10 unused addresses
        for (int a = 5; a < 8; a++) begin
            step(5'd0, 1'b1, 3'(a), 5'b11111, "R10 write");
            idle(3'(a), "R10 read zero");
        end
        idle(3'd0, "R10 stat kept");
        idle(3'd2, "R10 en kept");
        // random mix, fixed seed
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] e;
            logic [2:0] a;
            e = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
            a = 3'($urandom);
            step(e, ($urandom % 3) != 0, a, 5'($urandom), "R7 random");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule